// File: doc/BRIEF.md
# Chained Converter Frame Reader

This block reads conversion results from two delta-sigma converters of four channels each. The two converters are chained on one serial data line and send their results in fixed time slots. After power is good it issues one active-low synchronization pulse and then holds that line high for good. It then ignores the data-ready events of a fixed settling window. After that window, every falling edge of the active-low data-ready input starts one read of the 192-bit chained frame. The read runs on a serial clock that the block generates from its own clock by a selectable power-of-two division.

Each completed frame is split into eight 24-bit two's-complement channel words. The words are held on a valid/ready output until the consumer takes them. Three status outputs report trouble. A sticky overrun flag is set when a data-ready edge arrives during a read. A sticky timeout flag is set when data-ready edges stop arriving. A saturating counter counts frames dropped because the previous one was never accepted. The serial clock is always driven and rests low whenever no read is running.

Top module: `tfr_frame_reader`

## Requirements
- R1: While reset is asserted, and right after it is released: `sync_n` is 1, `sclk` is 0, `out_valid`, `overrun` and `timeout` are 0, and `lost_count` is 0.
- R2: Once `pwr_good` is seen high, `sync_n` goes low for exactly SYNC_LOW clock cycles, and only once. After that it stays high until the next reset.
- R3: The first BLANK_PERIODS data-ready falling edges after the sync pulse start no read. They cause no `sclk` pulse and no `out_valid`.
- R4: Each later data-ready falling edge, when no read is running, starts a read of exactly 192 `sclk` rising edges. `sclk` is 0 after the read and between reads.
- R5: `sclk` stays high for 2^`div_sel` clock cycles, and low for the same time, while a read is running. `div_sel` = 0, 1, 2 or 3.
- R6: `dout` is sampled as `sclk` falls, MSB first. The first 24 bits received, which are channel 1 of the first converter, appear on `out_words[23:0]`. Channel word k (k = 0..7) appears on `out_words[24k+23:24k]`, MSB of the word at the top bit.
- R7: `out_valid` and `out_words` hold their values until a cycle with `out_ready` = 1. After that cycle `out_valid` is 0, unless a new frame completes in that same cycle.
- R8: If a frame completes while `out_valid` = 1 and `out_ready` = 0, the held words stay unchanged. `lost_count` then increments by one and saturates at its all-ones value.
- R9: A data-ready falling edge that arrives during a read sets `overrun`, which stays set until reset. That edge starts no new read, and the read already running completes with its 192 edges.
- R10: After the sync pulse, `timeout` is set, and stays set until reset, when no data-ready falling edge is seen for more than 1.5 conversion periods. The conversion period is PERIOD_LS clocks when `mode` = 0 and PERIOD_HR clocks when `mode` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the base of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies stable; starts the sync sequence |
| mode | input | 1 | 0: low-speed conversion period, 1: high-resolution period |
| div_sel | input | 2 | Serial clock half-period is 2^div_sel clocks |
| drdy_n | input | 1 | Active-low data ready from the converters |
| dout | input | 1 | Serial data from the converter chain |
| sync_n | output | 1 | Active-low synchronization to the converters |
| sclk | output | 1 | Serial clock, always driven |
| out_valid | output | 1 | Channel words are held and valid |
| out_ready | input | 1 | Consumer accepts the held words |
| out_words | output | 192 | Eight 24-bit channel words, word k at bits 24k+23:24k |
| overrun | output | 1 | Sticky: data-ready edge arrived during a read |
| timeout | output | 1 | Sticky: data-ready edges stopped |
| lost_count | output | 8 | Saturating count of frames dropped while output was held |

## Verification
A wrong bit counter or a wrong divider state shows at the ports within one frame. The number of `sclk` rising edges per read differs from 192, or the high time of `sclk` does not match the selected division. A slip in the shift register or the unpacking shows as channel words out of place or rotated once the frame completes. A wrong settling counter shows as `sclk` activity during the settling window, or as a missing read on the first edge after it. A broken timeout counter shows within 1.5 periods of the selected mode. The bench checks that window on both sides of its limit.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef enum logic [1:0] {
    SQ_WAIT_PG = 2'd0,
    SQ_PULSE   = 2'd1,
    SQ_RUN     = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tfr_sync_ctrl.sv
module tfr_sync_ctrl #(
  parameter int SYNC_LOW      = 4,
  parameter int BLANK_PERIODS = 129,
  parameter int PERIOD_LS     = 2560,
  parameter int PERIOD_HR     = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic drdy_n,
  input  logic mode,
  output logic sync_n,
  output logic rd_evt,
  output logic timeout
);
  import tfr_pkg::*;

  localparam int LIM_LS = PERIOD_LS + PERIOD_LS / 2;
  localparam int LIM_HR = PERIOD_HR + PERIOD_HR / 2;
  localparam int TO_W   = $clog2(LIM_LS + 2);
  localparam int BL_W   = $clog2(BLANK_PERIODS + 1);
  localparam int SL_W   = $clog2(SYNC_LOW + 1);

  seq_state_t      st_q, st_d;
  logic [1:0]      pg_s;
  logic [2:0]      dr_s;
  logic [SL_W-1:0] pcnt_q, pcnt_d;
  logic [BL_W-1:0] bcnt_q, bcnt_d;
  logic [TO_W-1:0] tcnt_q, tcnt_d;
  logic            to_q, to_d;
  logic            fall;
  logic [TO_W-1:0] lim;

  assign fall = dr_s[2] & ~dr_s[1];
  assign lim  = mode ? TO_W'(LIM_HR) : TO_W'(LIM_LS);

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    bcnt_d = bcnt_q;
    tcnt_d = tcnt_q;
    to_d   = to_q;
    rd_evt = 1'b0;
    case (st_q)
      SQ_WAIT_PG: if (pg_s[1]) begin
        st_d   = SQ_PULSE;
        pcnt_d = '0;
      end
      SQ_PULSE: begin
        pcnt_d = pcnt_q + 1'b1;
        if (pcnt_q == SL_W'(SYNC_LOW - 1)) begin
          st_d   = SQ_RUN;
          tcnt_d = '0;
          bcnt_d = '0;
        end
      end
      default: begin
        if (fall) begin
          tcnt_d = '0;
          if (bcnt_q < BL_W'(BLANK_PERIODS)) bcnt_d = bcnt_q + 1'b1;
          else rd_evt = 1'b1;
        end else if (tcnt_q <= lim) begin
          tcnt_d = tcnt_q + 1'b1;
        end
        if (!fall && tcnt_q > lim) to_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_WAIT_PG;
      pg_s   <= '0;
      dr_s   <= '1;
      pcnt_q <= '0;
      bcnt_q <= '0;
      tcnt_q <= '0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pg_s   <= {pg_s[0], pwr_good};
      dr_s   <= {dr_s[1:0], drdy_n};
      pcnt_q <= pcnt_d;
      bcnt_q <= bcnt_d;
      tcnt_q <= tcnt_d;
      to_q   <= to_d;
    end
  end

  assign sync_n  = (st_q != SQ_PULSE);
  assign timeout = to_q;
endmodule

// File: rtl/tfr_shifter.sv
module tfr_shifter #(
  parameter int FRAME_W = 192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_evt,
  input  logic [1:0]         div_sel,
  input  logic               dout,
  output logic               sclk,
  output logic               busy,
  output logic               done,
  output logic               overrun,
  output logic [FRAME_W-1:0] frame
);
  localparam int BC_W = $clog2(FRAME_W);

  logic               busy_d, sclk_d, done_d, ovr_d;
  logic [3:0]         hcnt_q, hcnt_d, half_m1;
  logic [1:0]         div_q, div_d;
  logic [BC_W-1:0]    bcnt_q, bcnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               busy_q, sclk_q, done_q, ovr_q;

  assign half_m1 = (4'd1 << div_q) - 4'd1;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    div_d  = div_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    ovr_d  = ovr_q | (rd_evt & busy_q);
    if (!busy_q) begin
      sclk_d = 1'b0;
      if (rd_evt) begin
        busy_d = 1'b1;
        hcnt_d = '0;
        bcnt_d = '0;
        div_d  = div_sel;
      end
    end else if (hcnt_q == half_m1) begin
      hcnt_d = '0;
      sclk_d = ~sclk_q;
      if (sclk_q) begin
        sh_d = {sh_q[FRAME_W-2:0], dout};
        if (bcnt_q == BC_W'(FRAME_W - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      div_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
      div_q  <= div_d;
      sh_q   <= sh_d;
    end
  end

  assign sclk    = sclk_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign overrun = ovr_q;
  assign frame   = sh_q;
endmodule

// File: rtl/tfr_out_stage.sv
module tfr_out_stage #(
  parameter int CHANS  = 8,
  parameter int WORD_W = 24,
  parameter int LOST_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    done,
  input  logic [CHANS*WORD_W-1:0] frame,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [CHANS*WORD_W-1:0] out_words,
  output logic [LOST_W-1:0]       lost_count
);
  localparam int FW = CHANS * WORD_W;

  logic [FW-1:0]     unpacked, words_q, words_d;
  logic              val_q, val_d;
  logic [LOST_W-1:0] lost_q, lost_d;

  for (genvar k = 0; k < CHANS; k++) begin : g_unpack
    assign unpacked[k*WORD_W +: WORD_W] = frame[FW-1-k*WORD_W -: WORD_W];
  end

  always_comb begin
    words_d = words_q;
    val_d   = val_q;
    lost_d  = lost_q;
    if (done && (!val_q || out_ready)) begin
      words_d = unpacked;
      val_d   = 1'b1;
    end else if (done) begin
      if (lost_q != '1) lost_d = lost_q + 1'b1;
    end else if (out_ready) begin
      val_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      val_q   <= 1'b0;
      lost_q  <= '0;
    end else begin
      words_q <= words_d;
      val_q   <= val_d;
      lost_q  <= lost_d;
    end
  end

  assign out_valid  = val_q;
  assign out_words  = words_q;
  assign lost_count = lost_q;
endmodule

// File: rtl/tfr_frame_reader.sv
module tfr_frame_reader #(
  parameter int DEVS          = 2,
  parameter int CH_PER_DEV    = 4,
  parameter int WORD_W        = 24,
  parameter int LOST_W        = 8,
  parameter int SYNC_LOW      = 4,
  parameter int BLANK_PERIODS = 129,
  parameter int PERIOD_LS     = 2560,
  parameter int PERIOD_HR     = 512,
  localparam int CHANS        = DEVS * CH_PER_DEV,
  localparam int FRAME_W      = CHANS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic               mode,
  input  logic [1:0]         div_sel,
  input  logic               drdy_n,
  input  logic               dout,
  output logic               sync_n,
  output logic               sclk,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_words,
  output logic               overrun,
  output logic               timeout,
  output logic [LOST_W-1:0]  lost_count
);
  logic               rd_evt, shift_busy, shift_done;
  logic [FRAME_W-1:0] frame;

  tfr_sync_ctrl #(
    .SYNC_LOW(SYNC_LOW), .BLANK_PERIODS(BLANK_PERIODS),
    .PERIOD_LS(PERIOD_LS), .PERIOD_HR(PERIOD_HR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .drdy_n(drdy_n),
    .mode(mode), .sync_n(sync_n), .rd_evt(rd_evt), .timeout(timeout)
  );

  tfr_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .div_sel(div_sel),
    .dout(dout), .sclk(sclk), .busy(shift_busy), .done(shift_done),
    .overrun(overrun), .frame(frame)
  );

  tfr_out_stage #(.CHANS(CHANS), .WORD_W(WORD_W), .LOST_W(LOST_W)) u_out (
    .clk(clk), .rst_n(rst_n), .done(shift_done), .frame(frame),
    .out_ready(out_ready), .out_valid(out_valid), .out_words(out_words),
    .lost_count(lost_count)
  );
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int FRAME_W = 192,
  parameter int LOST_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_n,
  input logic               sclk,
  input logic               busy,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FRAME_W-1:0] out_words,
  input logic               overrun,
  input logic               timeout,
  input logic [LOST_W-1:0]  lost_count
);
  logic sync_prev, sync_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev <= 1'b1;
      sync_seen <= 1'b0;
    end else begin
      sync_prev <= sync_n;
      if (!sync_prev && sync_n) sync_seen <= 1'b1;
    end
  end

  p_sync_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_seen |-> sync_n);

  p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !sclk);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_words)));

  p_lost_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_count != '1) |=> (lost_count >= $past(lost_count)));

  p_lost_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_count == '1) |=> (lost_count == '1));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_timeout_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);

  p_no_sclk_in_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !sclk);
endmodule

bind tfr_frame_reader tfr_checker #(.FRAME_W(FRAME_W), .LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .busy(shift_busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_words(out_words),
  .overrun(overrun), .timeout(timeout), .lost_count(lost_count)
);

// File: tb/tb_tfr_frame_reader.sv
`timescale 1ns/1ps
module tb_tfr_frame_reader;
  localparam int FW = 192;

  logic          clk, rst_n, pwr_good, mode, drdy_n, dout, out_ready;
  logic [1:0]    div_sel;
  logic          sync_n, sclk, out_valid, overrun, timeout;
  logic [FW-1:0] out_words;
  logic [7:0]    lost_count;

  int n_chk = 0;
  int n_bad = 0;
  int rises = 0;
  int bit_idx = 0;
  int hi_cycles = 0;
  realtime t_rise = 0;
  logic [FW-1:0] tx;
  logic [FW-1:0] exp_a, exp_c;

  tfr_frame_reader #(
    .SYNC_LOW(4), .BLANK_PERIODS(3), .PERIOD_LS(1600), .PERIOD_HR(800)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode(mode),
    .div_sel(div_sel), .drdy_n(drdy_n), .dout(dout), .sync_n(sync_n),
    .sclk(sclk), .out_valid(out_valid), .out_ready(out_ready),
    .out_words(out_words), .overrun(overrun), .timeout(timeout),
    .lost_count(lost_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // converter model: launches the next bit on each sclk rise
  always @(negedge drdy_n) bit_idx = 0;
  always @(posedge sclk) begin
    rises <= rises + 1;
    t_rise = $realtime;
    if (bit_idx < FW) dout <= tx[FW-1-bit_idx];
    bit_idx = bit_idx + 1;
  end
  always @(negedge sclk) hi_cycles = int'(($realtime - t_rise) / 8.0);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input int act, input int expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic chk_words(input logic [FW-1:0] act, input logic [FW-1:0] expv,
                           input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_drdy();
    @(negedge clk) drdy_n = 1'b0;
    cycles(4);
    drdy_n = 1'b1;
  endtask

  // builds the serial frame and the expected unpacked words (word k at 24k)
  task automatic make_frame(input int seed, output logic [FW-1:0] exp_w);
    for (int k = 0; k < 8; k++) begin
      logic [23:0] w;
      w = 24'((seed * 8 + k + 1) * 24'h05A3C7) ^ 24'hA50F00;
      tx[FW-1-24*k -: 24] = w;
      exp_w[24*k +: 24] = w;
    end
  endtask

  task automatic t_reset();
    cycles(2);
    chk(sync_n, 1, "R1 sync_n in reset");
    chk(sclk, 0, "R1 sclk in reset");
    chk(out_valid, 0, "R1 out_valid in reset");
    rst_n = 1'b1;
    cycles(3);
    chk({overrun, timeout}, 0, "R1 flags after reset");
    chk(lost_count, 0, "R1 lost_count after reset");
  endtask

  task automatic t_sync();
    int lows = 0;
    pwr_good = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sync_n) lows++;
    end
    chk(lows, 4, "R2 sync low length");
    chk(sync_n, 1, "R2 sync high after pulse");
  endtask

  task automatic t_blank();
    int r0 = rises;
    logic [FW-1:0] dummy;
    make_frame(9, dummy);
    for (int i = 0; i < 3; i++) begin
      pulse_drdy();
      cycles(400);
    end
    chk(rises - r0, 0, "R3 no sclk in settling window");
    chk(out_valid, 0, "R3 no frame in settling window");
  endtask

  task automatic t_first_frame();
    int r0 = rises;
    div_sel = 2'd0;
    out_ready = 1'b0;
    make_frame(1, exp_a);
    pulse_drdy();
    cycles(600);
    chk(rises - r0, 192, "R4 edges per frame");
    chk(sclk, 0, "R4 sclk parked low");
    chk(out_valid, 1, "R4 frame after settling");
    chk_words(out_words, exp_a, "R6 channel order div1");
    chk(hi_cycles, 1, "R5 half period div_sel=0");
    cycles(100);
    chk(out_valid, 1, "R7 valid held");
    chk_words(out_words, exp_a, "R7 words held");
  endtask

  task automatic t_lost();
    logic [FW-1:0] exp_b;
    make_frame(2, exp_b);
    pulse_drdy();
    cycles(600);
    chk(lost_count, 1, "R8 lost count incremented");
    chk_words(out_words, exp_a, "R8 held words kept");
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    chk(out_valid, 0, "R7 valid cleared on ready");
  endtask

  task automatic t_div4();
    div_sel = 2'd2;
    make_frame(3, exp_c);
    pulse_drdy();
    cycles(1650);
    chk(out_valid, 1, "R4 frame div_sel=2");
    chk_words(out_words, exp_c, "R6 channel order div_sel=2");
    chk(hi_cycles, 4, "R5 half period div_sel=2");
    chk(overrun, 0, "R9 no overrun on spaced frames");
    chk(timeout, 0, "R10 no timeout on regular edges");
    @(negedge clk) out_ready = 1'b1;
  endtask

  task automatic t_overrun();
    int r0 = rises;
    logic [FW-1:0] dummy;
    div_sel = 2'd0;
    make_frame(4, dummy);
    pulse_drdy();
    cycles(100);
    pulse_drdy();
    cycles(600);
    chk(overrun, 1, "R9 overrun set");
    chk(rises - r0, 192, "R9 second edge starts no read");
    cycles(50);
    chk(overrun, 1, "R9 overrun sticky");
  endtask

  task automatic t_timeout();
    mode = 1'b1;
    pulse_drdy();
    cycles(1100);
    chk(timeout, 0, "R10 no timeout inside 1.5 periods");
    cycles(200);
    chk(timeout, 1, "R10 timeout after 1.5 periods");
    chk(sync_n, 1, "R2 sync held high");
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; mode = 1'b0; div_sel = 2'd0;
    drdy_n = 1'b1; dout = 1'b0; out_ready = 1'b0; tx = '0;
    exp_a = '0; exp_c = '0;
    t_reset();
    t_sync();
    t_blank();
    t_first_frame();
    t_lost();
    t_div4();
    t_overrun();
    t_timeout();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end
endmodule